// File: doc/BRIEF.md
# Calibration DAC Serial Writer

This block programs one of eight calibration trims held in two small serial DACs that share a two-wire bus. The host presents a channel index and a 12-bit trim value with a one-cycle request. The block selects which of the two devices to address from the channel, builds a four-byte frame (address, pointer, flags with the value's high nibble, value low byte) and shifts it out by driving the clock and data lines. Each line is an open-drain pull-down enable, and the block never reads either line back.

Every line change is followed by a settle wait. The wait after releasing a line high is much longer than the wait after pulling it low, and both lengths are parameters in clock cycles. The acknowledge slot after each byte is clocked with data released, and the acknowledge is never sampled. A channel index outside 0 to 7 is refused with a one-cycle error pulse and the bus is left untouched.

Top module: `cal_dac_i2c_writer`

## Requirements
- R1: After reset, and whenever the block is idle, both pull outputs are 0 (lines released) and `busy`, `done` and `err` are 0. Asserting reset mid-transfer releases both lines at once.
- R2: A transfer is a stop condition (SCL low, SDA low, SCL high, SDA high), then a start condition (SCL high, SDA high, SDA low), then four bytes, then a second stop condition. Each byte is eight data bits MSB first followed by an acknowledge slot (SCL low, SDA released, SCL high) that is never sampled.
- R3: Byte 1 is the 7-bit device address shifted left one place with bit 0 equal to 0. Channel bit 1 equal to 0 selects `DEV0_ADDR` (default 0x26, byte 0x4C), and equal to 1 selects `DEV1_ADDR` (default 0x27, byte 0x4E).
- R4: Byte 2 is the pointer. Channel bit 2 chooses gain (1) or offset (0), and channel bit 0 chooses the odd pair. The codes are: even offset 0x01, even gain 0x02, odd offset 0x04, odd gain 0x08.
- R5: Byte 3 is 0x20 OR value[11:8], and byte 4 is value[7:0].
- R6: Each line operation takes one cycle plus `HIGH_CYC` cycles when it drives a line high, or one cycle plus `LOW_CYC` cycles when it drives a line low. `busy` is high from the cycle after the request for exactly the sum of these costs.
- R7: Inside the four bytes, SDA changes only while SCL is low. Each bit is sent as SCL low, then SDA set, then SCL high.
- R8: A request with channel 8 or higher gives `err` high for the single cycle after the request. `busy` stays 0 and there is no bus activity.
- R9: A request that arrives while `busy` is high is dropped. It does not alter the frame in progress and does not start a transfer afterwards.
- R10: `done` is high for exactly one cycle, in the first cycle in which `busy` is low again after a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | One-cycle write request |
| chan | input | 4 | Calibration channel index (0 to 7 valid) |
| value | input | 12 | Trim value |
| scl_pull | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| err | output | 1 | One-cycle pulse for a refused channel |

## Verification
The assertions assume that no external agent drives the lines. They also assume that `req` is sampled only on clock edges and that both settle parameters are at least one cycle, so every line operation holds for at least two cycles. The stimulus keeps `req` to single-cycle pulses driven on the falling edge and uses short settle values. It sends a second request while a transfer runs, and applies reset only as the final step, so the bus monitor never sees a transfer cut off partway except in that deliberate last case.

// File: rtl/cdw_pkg.sv
package cdw_pkg;
  localparam int unsigned CHAN_W    = 4;
  localparam int unsigned VALUE_W   = 12;
  localparam int unsigned NUM_BYTES = 4;
  localparam int unsigned FRAME_W   = 8 * NUM_BYTES;
  localparam int unsigned BIT_W     = 4;  // counts 8 data bits plus the ack slot
  localparam logic [7:0]  KEEP_FLAG = 8'h20;

  typedef enum logic [1:0] {ST_IDLE, ST_APPLY, ST_WAIT} seq_state_e;
  typedef enum logic [1:0] {SEG_HEAD_STOP, SEG_START, SEG_BYTES, SEG_TAIL_STOP} seg_e;

  typedef struct packed {
    logic on_scl;  // 1: operation targets the clock line
    logic level;   // line level after the operation
  } line_op_t;
endpackage

// File: rtl/cdw_frame_build.sv
module cdw_frame_build
  import cdw_pkg::*;
#(
  parameter logic [6:0] DEV0_ADDR = 7'h26,
  parameter logic [6:0] DEV1_ADDR = 7'h27
) (
  input  logic [CHAN_W-1:0]  chan,
  input  logic [VALUE_W-1:0] value,
  output logic [FRAME_W-1:0] frame,
  output logic               chan_ok
);
  logic [6:0] dev;
  logic [7:0] ptr;

  always_comb begin
    chan_ok = (chan < CHAN_W'(8));
    dev     = chan[1] ? DEV1_ADDR : DEV0_ADDR;
    // bit 0 of chan picks the odd pair, bit 2 picks gain over offset
    ptr     = 8'h01 << {chan[0], chan[2]};
    frame   = {dev, 1'b0, ptr, KEEP_FLAG | {4'h0, value[11:8]}, value[7:0]};
  end
endmodule

// File: rtl/cdw_settle.sv
module cdw_settle #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // once the wait has run out it stays out until a new operation reloads it
  assert_expired_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);
endmodule

// File: rtl/cdw_seq.sv
module cdw_seq
  import cdw_pkg::*;
#(
  parameter int unsigned HIGH_CYC = 250000,
  parameter int unsigned LOW_CYC  = 2500
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               scl_lvl,
  output logic               sda_lvl,
  output logic               busy,
  output logic               done
);
  localparam int unsigned MAX_CYC = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
  localparam int unsigned TW      = $clog2(MAX_CYC + 1);
  localparam int unsigned LAST_BYTE = NUM_BYTES - 1;

  seq_state_e         state_q, state_d;
  seg_e               seg_q, seg_d;
  logic [1:0]         sub_q, sub_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [1:0]         byte_q, byte_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               sh_en;
  logic               scl_q, scl_d, sda_q, sda_d, done_q, done_d;
  line_op_t           op;
  logic               expired;
  logic [TW-1:0]      wait_val;

  // operation selected by the current position in the frame
  always_comb begin
    op = '{on_scl: 1'b1, level: 1'b1};
    unique case (seg_q)
      SEG_HEAD_STOP, SEG_TAIL_STOP: begin
        op.on_scl = ~sub_q[0];
        op.level  = sub_q[1];
      end
      SEG_START: begin
        op.on_scl = (sub_q == 2'd0);
        op.level  = (sub_q != 2'd2);
      end
      default: begin
        op.on_scl = (sub_q != 2'd1);
        if (sub_q == 2'd1) op.level = (bit_q == BIT_W'(8)) ? 1'b1 : sh_q[FRAME_W-1];
        else               op.level = (sub_q == 2'd2);
      end
    endcase
  end

  assign wait_val = op.level ? TW'(HIGH_CYC - 1) : TW'(LOW_CYC - 1);

  cdw_settle #(.W(TW)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (state_q == ST_APPLY),
    .load_val(wait_val),
    .expired (expired)
  );

  always_comb begin
    state_d = state_q;
    seg_d   = seg_q;
    sub_d   = sub_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    sh_d    = sh_q;
    sh_en   = 1'b0;
    scl_d   = scl_q;
    sda_d   = sda_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_APPLY;
        seg_d   = SEG_HEAD_STOP;
        sub_d   = 2'd0;
        bit_d   = '0;
        byte_d  = 2'd0;
        sh_d    = frame_in;
        sh_en   = 1'b1;
      end
      ST_APPLY: begin
        if (op.on_scl) scl_d = op.level;
        else           sda_d = op.level;
        state_d = ST_WAIT;
      end
      default: if (expired) begin
        state_d = ST_APPLY;
        unique case (seg_q)
          SEG_HEAD_STOP, SEG_TAIL_STOP: begin
            if (sub_q != 2'd3) sub_d = sub_q + 2'd1;
            else if (seg_q == SEG_HEAD_STOP) begin
              seg_d = SEG_START;
              sub_d = 2'd0;
            end else begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end
          SEG_START: begin
            if (sub_q != 2'd2) sub_d = sub_q + 2'd1;
            else begin
              seg_d = SEG_BYTES;
              sub_d = 2'd0;
            end
          end
          default: begin
            if (sub_q != 2'd2) sub_d = sub_q + 2'd1;
            else begin
              sub_d = 2'd0;
              if (bit_q != BIT_W'(8)) begin
                bit_d = bit_q + BIT_W'(1);
                sh_d  = {sh_q[FRAME_W-2:0], 1'b0};
                sh_en = 1'b1;
              end else begin
                bit_d = '0;
                if (byte_q == 2'(LAST_BYTE)) seg_d = SEG_TAIL_STOP;
                else                          byte_d = byte_q + 2'd1;
              end
            end
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      seg_q   <= SEG_HEAD_STOP;
      sub_q   <= 2'd0;
      bit_q   <= '0;
      byte_q  <= 2'd0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      seg_q   <= seg_d;
      sub_q   <= sub_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign scl_lvl = scl_q;
  assign sda_lvl = sda_q;
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (scl_q && sda_q));

  assert_data_under_low_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_APPLY && seg_q == SEG_BYTES && !op.on_scl) |-> !scl_q);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_done_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_IDLE));
endmodule

// File: rtl/cal_dac_i2c_writer.sv
module cal_dac_i2c_writer
  import cdw_pkg::*;
#(
  parameter int unsigned HIGH_CYC  = 250000,
  parameter int unsigned LOW_CYC   = 2500,
  parameter logic [6:0]  DEV0_ADDR = 7'h26,
  parameter logic [6:0]  DEV1_ADDR = 7'h27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [3:0]   chan,
  input  logic [11:0]  value,
  output logic         scl_pull,
  output logic         sda_pull,
  output logic         busy,
  output logic         done,
  output logic         err
);
  logic [1:0]         rst_sync_q;
  logic               rst_i_n;
  logic [FRAME_W-1:0] frame;
  logic               chan_ok;
  logic               start;
  logic               err_q, err_d;
  logic               scl_lvl, sda_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  cdw_frame_build #(.DEV0_ADDR(DEV0_ADDR), .DEV1_ADDR(DEV1_ADDR)) u_frame (
    .chan   (chan),
    .value  (value),
    .frame  (frame),
    .chan_ok(chan_ok)
  );

  always_comb begin
    start = req && !busy && chan_ok;
    err_d = req && !busy && !chan_ok;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) err_q <= 1'b0;
    else          err_q <= err_d;
  end

  cdw_seq #(.HIGH_CYC(HIGH_CYC), .LOW_CYC(LOW_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .start   (start),
    .frame_in(frame),
    .scl_lvl (scl_lvl),
    .sda_lvl (sda_lvl),
    .busy    (busy),
    .done    (done)
  );

  assign scl_pull = ~scl_lvl;
  assign sda_pull = ~sda_lvl;
  assign err      = err_q;

  initial begin
    assert_settle_nonzero_R6: assert (HIGH_CYC >= 1 && LOW_CYC >= 1);
  end

  assert_err_no_bus_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    err_q |-> (!busy && !scl_pull && !sda_pull));

  assert_busy_keeps_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && req && !done) |=> (busy || done));
endmodule

// File: tb/cal_dac_i2c_writer_bench.sv
`timescale 1ns/1ps
module cal_dac_i2c_writer_bench;
  localparam int unsigned HI = 6;
  localparam int unsigned LO = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [3:0]  chan;
  logic [11:0] value;
  logic        scl_pull, sda_pull, busy, done, err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  cal_dac_i2c_writer #(.HIGH_CYC(HI), .LOW_CYC(LO), .DEV0_ADDR(7'h26), .DEV1_ADDR(7'h27))
  u_cal_dac_i2c_writer (
    .clk(clk), .rst_n(rst_n), .req(req), .chan(chan), .value(value),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy), .done(done), .err(err)
  );

  // channel, value, address byte, pointer, flags byte, low byte
  localparam logic [47:0] VEC [8] = '{
    {4'd0, 12'hABC, 8'h4C, 8'h01, 8'h2A, 8'hBC},
    {4'd1, 12'h000, 8'h4C, 8'h04, 8'h20, 8'h00},
    {4'd2, 12'hFFF, 8'h4E, 8'h01, 8'h2F, 8'hFF},
    {4'd3, 12'h123, 8'h4E, 8'h04, 8'h21, 8'h23},
    {4'd4, 12'h800, 8'h4C, 8'h02, 8'h28, 8'h00},
    {4'd5, 12'h0FF, 8'h4C, 8'h08, 8'h20, 8'hFF},
    {4'd6, 12'h5A5, 8'h4E, 8'h02, 8'h25, 8'hA5},
    {4'd7, 12'h7E1, 8'h4E, 8'h08, 8'h27, 8'hE1}
  };

  // bus monitor, sampled on the falling edge
  logic [7:0] mon_buf [64];
  int mon_nbytes = 0, mon_starts = 0, mon_stops = 0, mon_ack_low = 0;
  int nbit = 0;
  bit in_frame = 0;
  logic [7:0] shreg = '0;
  logic p_scl = 1'b1, p_sda = 1'b1;

  always @(negedge clk) begin
    logic s_scl, s_sda;
    s_scl = ~scl_pull;
    s_sda = ~sda_pull;
    if (s_scl && p_scl && s_sda && !p_sda) begin
      mon_stops++;
      in_frame = 0;
    end else if (s_scl && p_scl && !s_sda && p_sda) begin
      mon_starts++;
      in_frame = 1;
      nbit = 0;
    end else if (s_scl && !p_scl && in_frame) begin
      if (nbit < 8) shreg = {shreg[6:0], s_sda};
      nbit++;
      if (nbit == 9) begin
        mon_buf[mon_nbytes % 64] = shreg;
        mon_nbytes++;
        if (!s_sda) mon_ack_low++;
        nbit = 0;
      end
    end
    p_scl = s_scl;
    p_sda = s_sda;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", rq, act, exp);
    end
  endtask

  function automatic int exp_cycles(input logic [31:0] fr);
    int l = LO + 1;
    int h = HI + 1;
    int t = 2 * (2 * l + 2 * h) + 2 * h + l;
    for (int i = 31; i >= 0; i--) t += l + (fr[i] ? h : l) + h;
    t += 4 * (l + 2 * h);
    return t;
  endfunction

  task automatic run_txn(input logic [3:0] ch, input logic [11:0] v,
                         input logic [31:0] exp_fr, input int inject_at);
    int b0 = mon_nbytes;
    int st0 = mon_starts;
    int sp0 = mon_stops;
    int ak0 = mon_ack_low;
    int n = 0;
    int guard = 0;
    @(negedge clk);
    req = 1'b1; chan = ch; value = v;
    @(negedge clk);
    req = 1'b0;
    while (!done && guard < 20000) begin
      if (busy) n++;
      if (n == inject_at) begin req = 1'b1; chan = 4'd7; value = 12'h000; end
      else req = 1'b0;
      @(negedge clk);
      guard++;
    end
    req = 1'b0;
    chk(n == exp_cycles(exp_fr), "R6 busy length", n, exp_cycles(exp_fr));
    chk(busy == 1'b0 && done == 1'b1, "R10 done with busy low", {busy, done}, 2'b01);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
    chk(mon_nbytes - b0 == 4, "R2 byte count", mon_nbytes - b0, 4);
    chk(mon_starts - st0 == 1, "R2 start count", mon_starts - st0, 1);
    chk(mon_stops - sp0 == 2, "R2 stop count", mon_stops - sp0, 2);
    chk(mon_ack_low == ak0, "R2 ack slot released", mon_ack_low - ak0, 0);
    chk(mon_buf[b0 % 64] == exp_fr[31:24], "R3 address byte", mon_buf[b0 % 64], exp_fr[31:24]);
    chk(mon_buf[(b0 + 1) % 64] == exp_fr[23:16], "R4 pointer byte",
        mon_buf[(b0 + 1) % 64], exp_fr[23:16]);
    chk(mon_buf[(b0 + 2) % 64] == exp_fr[15:8] && mon_buf[(b0 + 3) % 64] == exp_fr[7:0],
        "R5 value bytes", {mon_buf[(b0 + 2) % 64], mon_buf[(b0 + 3) % 64]}, exp_fr[15:0]);
    chk(scl_pull == 1'b0 && sda_pull == 1'b0, "R1 released after transfer",
        {scl_pull, sda_pull}, 0);
  endtask

  task automatic bad_chan(input logic [3:0] ch);
    int st0 = mon_starts;
    bit quiet = 1;
    @(negedge clk);
    req = 1'b1; chan = ch; value = 12'h3C3;
    @(negedge clk);
    req = 1'b0;
    chk(err == 1'b1 && busy == 1'b0, "R8 err pulse without busy", {err, busy}, 2'b10);
    @(negedge clk);
    chk(err == 1'b0, "R8 err one cycle", err, 0);
    for (int i = 0; i < 20; i++) begin
      if (busy || scl_pull || sda_pull) quiet = 0;
      @(negedge clk);
    end
    chk(quiet && mon_starts == st0, "R8 no bus activity", mon_starts - st0, 0);
  endtask

  initial begin
    req = 1'b0; chan = '0; value = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(scl_pull == 0 && sda_pull == 0 && busy == 0 && done == 0 && err == 0,
        "R1 reset state", {scl_pull, sda_pull, busy, done, err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: every channel, covering R3 R4 R5 R6 R7
    for (int k = 0; k < 8; k++) begin
      run_txn(VEC[k][47:44], VEC[k][43:32], VEC[k][31:0], -1);
    end

    // R9: a request mid-transfer is dropped
    begin
      int st0;
      bit stayed = 1;
      run_txn(4'd0, 12'hABC, {8'h4C, 8'h01, 8'h2A, 8'hBC}, 50);
      st0 = mon_starts;
      for (int i = 0; i < 10; i++) begin
        if (busy) stayed = 0;
        @(negedge clk);
      end
      chk(stayed && mon_starts == st0, "R9 dropped request not replayed", mon_starts - st0, 0);
    end

    // R8: refused channels
    bad_chan(4'd8);
    bad_chan(4'd15);

    // R1: reset in the middle of a transfer
    @(negedge clk);
    req = 1'b1; chan = 4'd2; value = 12'h000;
    @(negedge clk);
    req = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(scl_pull == 0 && sda_pull == 0 && busy == 0, "R1 reset mid transfer",
        {scl_pull, sda_pull, busy}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0, "R1 idle after reset", {busy, done, err}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule